// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flag

This block holds a bank of peripheral status flags. A hardware event sets each flag. Software clears a flag in two steps. First it reads the shared status register while the flag is set, which arms that flag's clear. Then it accesses that flag's associated data register, and the armed flag clears.

A debug halt signal and an enable bit together decide whether clearing may happen while the debugger has the core stopped. With the enable low, the debugger can read and write registers freely and no flag or arming state moves. An arming done before the halt is kept, so the second step can still be completed after the halt ends. With the enable high, clearing behaves normally during the halt, and a flag cleared then stays cleared.

Top module: `bfp_flag_bank`

## Requirements
- R1: Reset (rst_ni low) forces every flag_o and armed_o bit to 0.
- R2: set_i[k] high at a clock edge makes flag_o[k] 1 after that edge, in every mode, and leaves armed_o[k] as it was unless R9 applies.
- R3: status_rd_i high at an edge while unprotected arms every channel whose flag was 1 before that edge (armed_o 1 after it); a channel whose flag was 0 is not armed.
- R4: data_acc_i[k] high while armed_o[k] is 1, unprotected and without set_i[k] clears both flag_o[k] and armed_o[k] after that edge; an access while not armed changes nothing.
- R5: Protected mode is brk_i=1 with brk_clr_en_i=0. In protected mode data_acc_i leaves flag_o and armed_o unchanged.
- R6: In protected mode status_rd_i creates no new arming.
- R7: With brk_i=1 and brk_clr_en_i=1 the two-step clear works as in R3/R4, and the cleared flag stays 0 after brk_i falls.
- R8: An arming made before protected mode survives it, and a data access after brk_i falls clears the flag.
- R9: set_i[k] and a clearing data_acc_i[k] at the same edge leave flag_o[k]=1 and armed_o[k]=0.
- R10: Channels are independent: data_acc_i[k] and set_i[k] affect only channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | N_FLAGS | Per-channel set event |
| status_rd_i | input | 1 | Status register read strobe (first step) |
| data_acc_i | input | N_FLAGS | Per-channel data register access strobe (second step) |
| brk_i | input | 1 | Debug break mode level |
| brk_clr_en_i | input | 1 | Allow clearing during break |
| flag_o | output | N_FLAGS | Status flags |
| armed_o | output | N_FLAGS | First step completed, clear pending |

## Verification
The hardest state to reach is an arming that is carried across a protected break. The flag must be set, the first step must be taken outside break, and then second-step accesses and status reads must be tried inside break before break is dropped and the access is repeated. The vector table walks that exact sequence on channel 0, with combined read-and-access cycles inside break. It then runs a same-edge set-and-clear collision and checks that the cancelled arming no longer clears the flag.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } flag_act_e;
endpackage

// File: rtl/bfp_break_gate.sv
module bfp_break_gate (
  input  logic brk_i,
  input  logic brk_clr_en_i,
  output logic clr_allow_o
);
  // clearing is blocked only in break with the enable low
  assign clr_allow_o = ~(brk_i & ~brk_clr_en_i);
endmodule

// File: rtl/bfp_flag_cell.sv
module bfp_flag_cell
  import bfp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic status_rd_i,
  input  logic data_acc_i,
  input  logic clr_allow_i,
  output logic flag_o,
  output logic armed_o
);
  logic      flag_q, armed_q;
  logic      second_step;
  flag_act_e act;

  assign second_step = armed_q & data_acc_i & clr_allow_i;

  always_comb begin
    if (set_i)            act = ACT_SET;
    else if (second_step) act = ACT_CLEAR;
    else                  act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      case (act)
        ACT_SET:   flag_q <= 1'b1;
        ACT_CLEAR: flag_q <= 1'b0;
        default:   flag_q <= flag_q;
      endcase
      // a completed second step consumes the arming, even if set wins
      if (second_step)
        armed_q <= 1'b0;
      else if (status_rd_i & flag_q & clr_allow_i)
        armed_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R2
  AST_PROTECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_allow_i && !set_i) |=> $stable(flag_q)); // R5
  AST_PROTECT_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_allow_i && !armed_q) |=> !armed_q); // R6
  AST_ARMED_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> flag_q); // R3
  AST_CLEAR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && data_acc_i && clr_allow_i && !set_i) |=> (!flag_q && !armed_q)); // R4
  AST_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && data_acc_i && clr_allow_i && set_i) |=> (flag_q && !armed_q)); // R9
endmodule

// File: rtl/bfp_flag_bank.sv
module bfp_flag_bank #(
  parameter int N_FLAGS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic               status_rd_i,
  input  logic [N_FLAGS-1:0] data_acc_i,
  input  logic               brk_i,
  input  logic               brk_clr_en_i,
  output logic [N_FLAGS-1:0] flag_o,
  output logic [N_FLAGS-1:0] armed_o
);
  logic clr_allow;

  bfp_break_gate u_gate (
    .brk_i        (brk_i),
    .brk_clr_en_i (brk_clr_en_i),
    .clr_allow_o  (clr_allow)
  );

  for (genvar k = 0; k < N_FLAGS; k++) begin : g_cell
    bfp_flag_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (set_i[k]),
      .status_rd_i (status_rd_i),
      .data_acc_i  (data_acc_i[k]),
      .clr_allow_i (clr_allow),
      .flag_o      (flag_o[k]),
      .armed_o     (armed_o[k])
    );
  end

  AST_RESET_EMPTY: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (flag_o == '0 && armed_o == '0)); // R1
endmodule

// File: tb/bfp_flag_bank_bench.sv
module bfp_flag_bank_bench;
  localparam int N = 4;
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] set, acc;
  logic rd, brk, en;
  logic [N-1:0] flag, armed;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  bfp_flag_bank #(.N_FLAGS(N)) u_bfp_flag_bank (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set), .status_rd_i(rd),
    .data_acc_i(acc), .brk_i(brk), .brk_clr_en_i(en),
    .flag_o(flag), .armed_o(armed)
  );

  // {req, set, rd, acc, brk, en, exp_flag, exp_armed}; channel 0 only
  localparam logic [10:0] VEC [NV] = '{
    {4'd1,  7'b00000_00}, // R1 idle
    {4'd3,  7'b01000_00}, // R3 read while clear
    {4'd4,  7'b00100_00}, // R4 access unarmed
    {4'd2,  7'b10000_10}, // R2 set
    {4'd4,  7'b00100_10}, // R4 access unarmed, flag set
    {4'd3,  7'b01000_11}, // R3 arm
    {4'd4,  7'b00100_00}, // R4 clear
    {4'd2,  7'b10000_10},
    {4'd6,  7'b01010_10}, // R6 protected read
    {4'd5,  7'b00110_10}, // R5 protected access
    {4'd3,  7'b01000_11}, // arm before break
    {4'd8,  7'b00110_11}, // R8 protected access keeps arm
    {4'd5,  7'b01110_11}, // R5 read+access protected
    {4'd8,  7'b00000_11}, // R8 break left
    {4'd8,  7'b00100_00}, // R8 clear after break
    {4'd2,  7'b10000_10},
    {4'd7,  7'b01011_11}, // R7 arm in enabled break
    {4'd7,  7'b00111_00}, // R7 clear in enabled break
    {4'd7,  7'b00000_00}, // R7 stays clear
    {4'd2,  7'b10000_10},
    {4'd3,  7'b01000_11},
    {4'd9,  7'b10100_10}, // R9 set+clear collide
    {4'd9,  7'b00100_10}, // R9 arming cancelled
    {4'd3,  7'b01100_11}, // R3 read+access, unarmed
    {4'd2,  7'b10010_11}, // R2 set in protected break
    {4'd4,  7'b00100_00}  // R4 clear
  };

  task automatic chk(input string req, input logic [N-1:0] af, input logic [N-1:0] ef,
                     input logic [N-1:0] aa, input logic [N-1:0] ea);
    checks++;
    if (af !== ef || aa !== ea) begin
      errors++;
      $display("FAIL %s flag=%b exp=%b armed=%b exp=%b", req, af, ef, aa, ea);
    end
  endtask

  task automatic idle();
    set = '0; acc = '0; rd = 1'b0; brk = 1'b0; en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    chk("R1", flag, '0, armed, '0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {set[0], rd, acc[0], brk, en} = VEC[i][6:2];
      @(posedge clk); #1;
      chk($sformatf("R%0d vec%0d", VEC[i][10:7], i), flag, {3'b000, VEC[i][1]},
          armed, {3'b000, VEC[i][0]});
    end
    // R10: channels 1 and 2 set and armed, only channel 1 accessed
    @(negedge clk); idle(); set = 4'b0110;
    @(negedge clk); idle(); rd = 1'b1;
    @(negedge clk); idle(); acc = 4'b0010;
    @(negedge clk); idle();
    chk("R10", flag, 4'b0100, armed, 4'b0100);
    // R10: set on channel 3 only
    set = 4'b1000;
    @(negedge clk); idle();
    chk("R10 set", flag, 4'b1100, armed, 4'b0100);
    // R1: reset mid-run clears armed state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid", flag, '0, armed, '0);
    rst_n = 1'b1;
    @(negedge clk); acc = '1;
    @(negedge clk); idle();
    chk("R1 after", flag, '0, armed, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule